// File: doc/BRIEF.md
# I2C Target Clock-Stretch Controller

This block lives inside an I2C target and decides, cycle by cycle, whether the target should hold the SCL line low. It watches the bus through a synchronizer and finds START, STOP and SCL edges. It counts the falling edges that close each bit of a byte and captures each byte. From the first byte of every transfer it works out whether the target is addressed and in which direction the transfer runs. The only drive onto the bus is an active-high pull-low enable for an open-drain SCL pad.

Software controls stretching through a release bit. Writing 0 asks for a hold and writing 1 lets the clock run. The hardware clears the same bit on its own at defined points in a byte: after the acknowledge slot of a read, after every acknowledge when general stretching is enabled, and before the acknowledge slot of an address or data byte when the matching hold mode is on. In 10-bit address mode a separate update-pending flag holds SCL after each of the two address bytes, without touching the release bit. A strobe that stands for a write to the address register clears that flag. A hold only starts on a clock that is already low, so the block never cuts short a high phase.

Top module: `i2c_stretch_top`

## Requirements
- R1: A request to hold (release bit 0 or update flag 1) asserts `sclPullLow` only after the synchronized SCL is seen low. Once asserted, it stays asserted for as long as the request stands.
- R2: When the release bit is 1 and the update flag is 0, `sclPullLow` is 0 from the next cycle on. The line then rises as soon as the master also lets go.
- R3: In 7-bit mode, an address byte is bits 7..1 compared against `ownAddr`, and bit 0 gives the direction (1 = read). For a matched read transfer, the release bit is cleared at the 9th falling SCL edge of every byte.
- R4: With `stretchEn` set, the release bit is cleared at the 9th falling edge of every byte of a matched transfer, for writes as well as reads.
- R5: With `addrHoldEn` set, the release bit is cleared at the 8th falling edge of an address byte that matches. An address byte that does not match leaves it untouched.
- R6: With `dataHoldEn` set, the release bit is cleared at the 8th falling edge of each data byte the target receives in a matched write transfer.
- R7: In 10-bit mode, a first byte whose top five bits are 11110 selects the target. The update flag is then set at the 9th falling edge of the first and of the second byte, and SCL is held while the release bit stays 1. A pulse on `addrWrStb` clears the flag and frees SCL.
- R8: In 10-bit mode, the hold after the second address byte happens whatever that byte contains.
- R9: A STOP (SDA rising while SCL is high) sets the release bit to 1, clears the update flag and ends the transfer.
- R10: A START or repeated START (SDA falling while SCL is high) restarts the bit count and the byte count. The next byte is therefore taken as a fresh address byte, even when it breaks into a partial byte.
- R11: After reset the release bit is 1, the update flag is 0 and `sclPullLow` is 0.
- R12: Once a 7-bit address byte fails to match, no later byte of that transfer stretches the clock, even with `stretchEn` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL as seen on the bus (asynchronous) |
| sdaIn | input | 1 | SDA as seen on the bus (asynchronous) |
| ownAddr | input | 7 | Target 7-bit address |
| tenBitMode | input | 1 | Selects 10-bit addressing |
| stretchEn | input | 1 | Stretch after every acknowledge slot |
| addrHoldEn | input | 1 | Hold before the ACK slot of a matched address byte |
| dataHoldEn | input | 1 | Hold before the ACK slot of a received data byte |
| relWrEn | input | 1 | Software write strobe for the release bit |
| relWrVal | input | 1 | Value written to the release bit |
| addrWrStb | input | 1 | Strobe for a write to the address register |
| sclPullLow | output | 1 | Open-drain SCL pull-low enable |
| relBit | output | 1 | Current release bit |
| updPend | output | 1 | 10-bit address update pending |

## Verification
The assertions take for granted that the configuration inputs change only while the bus is idle. They also assume that no software write and no STOP fall in the same cycle as a hardware hold event. The bench respects both: it changes modes only between transfers, and it writes the release bit or strobes the address register only while a stretch is already holding the line. The master model changes SDA only while SCL is low, except where it means to form a START or STOP. It holds each SCL phase long enough for the two-stage synchronizer to settle, so no hold request can meet a clock that is high and already in flight.

// File: rtl/i2c_stretch_pkg.sv
package i2c_stretch_pkg;

  // 10-bit address header pattern in the upper bits of the first byte
  localparam int TEN_HDR_W = 5;
  localparam logic [TEN_HDR_W-1:0] TEN_HDR = 5'b11110;

  // strobes from bus datapath to hold control, valid for one clock
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic fall8;
    logic fall9;
    logic firstByte;
    logic secondByte;
    logic hdrMatch;
    logic dirBit;
  } busEvT;

endpackage

// File: rtl/i2c_stretch_dp.sv
module i2c_stretch_dp
  import i2c_stretch_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int BYTE_BITS  = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              tenBitMode,
  output logic              sclSync,
  output busEvT             busEv
);

  localparam int ACK_POS = BYTE_BITS + 1;
  localparam int CNT_W   = $clog2(ACK_POS + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ACK = CNT_W'(ACK_POS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS);

  logic [SYNC_DEPTH-1:0] sclPipe, sdaPipe;
  logic                  sclPrev, sdaPrev, sdaSync;
  logic [CNT_W-1:0]      bitCnt, nextCnt;
  logic                  armed;
  logic [BYTE_BITS-1:0]  shiftReg;
  logic [1:0]            byteIdx;
  logic                  fallE, riseE, startE, stopE, countFall;

  // two-flop (or deeper) synchronizers, idle-high reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_DEPTH-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_DEPTH-2:0], sdaIn};
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  assign sclSync = sclPipe[SYNC_DEPTH-1];
  assign sdaSync = sdaPipe[SYNC_DEPTH-1];

  always_comb begin
    fallE     = sclPrev & ~sclSync;
    riseE     = ~sclPrev & sclSync;
    startE    = sclSync & sclPrev & sdaPrev & ~sdaSync;
    stopE     = sclSync & sclPrev & ~sdaPrev & sdaSync;
    countFall = fallE & armed;
    nextCnt   = (bitCnt == CNT_ACK) ? CNT_ONE : bitCnt + CNT_ONE;
  end

  // bit/byte bookkeeping: falls are counted only after the first rise since START
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      armed    <= 1'b0;
      shiftReg <= '0;
      byteIdx  <= '0;
    end else if (startE) begin
      bitCnt  <= '0;
      armed   <= 1'b0;
      byteIdx <= '0;
    end else if (riseE) begin
      shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaSync};
      armed    <= 1'b1;
    end else if (countFall) begin
      bitCnt <= nextCnt;
      if (nextCnt == CNT_ACK && byteIdx != 2'd2) byteIdx <= byteIdx + 2'd1;
    end
  end

  logic matchSeven, matchTen;
  assign matchSeven = (shiftReg[BYTE_BITS-1 -: ADDR_W] == ownAddr);
  assign matchTen   = (shiftReg[BYTE_BITS-1 -: TEN_HDR_W] == TEN_HDR);

  always_comb begin
    busEv.startEv    = startE;
    busEv.stopEv     = stopE;
    busEv.fall8      = countFall & (nextCnt == CNT_LAST);
    busEv.fall9      = countFall & (nextCnt == CNT_ACK);
    busEv.firstByte  = (byteIdx == 2'd0);
    busEv.secondByte = (byteIdx == 2'd1);
    busEv.hdrMatch   = tenBitMode ? matchTen : matchSeven;
    busEv.dirBit     = shiftReg[0];
  end

endmodule

// File: rtl/i2c_stretch_ctl.sv
module i2c_stretch_ctl
  import i2c_stretch_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  busEvT busEv,
  input  logic  sclSync,
  input  logic  tenBitMode,
  input  logic  stretchEn,
  input  logic  addrHoldEn,
  input  logic  dataHoldEn,
  input  logic  relWrEn,
  input  logic  relWrVal,
  input  logic  addrWrStb,
  output logic  sclPullLow,
  output logic  relBit,
  output logic  updPend
);

  logic active, rdDir, pullQ;
  logic addrHold, dataByte, dataHold, ackHold, clrRel, setUpd, holdReq;

  always_comb begin
    addrHold = busEv.fall8 & busEv.firstByte & busEv.hdrMatch & addrHoldEn;
    dataByte = ~busEv.firstByte & ~(tenBitMode & busEv.secondByte);
    dataHold = busEv.fall8 & dataByte & active & ~rdDir & dataHoldEn;
    ackHold  = busEv.fall9 & active & (rdDir | stretchEn);
    clrRel   = addrHold | dataHold | ackHold;
    setUpd   = busEv.fall9 & tenBitMode & active & (busEv.firstByte | busEv.secondByte);
    holdReq  = ~relBit | updPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relBit  <= 1'b1;
      updPend <= 1'b0;
      active  <= 1'b0;
      rdDir   <= 1'b0;
      pullQ   <= 1'b0;
    end else begin
      // engage only on a low clock; keep holding while requested
      pullQ <= holdReq & (pullQ | ~sclSync);
      if (busEv.stopEv) begin
        relBit  <= 1'b1;
        updPend <= 1'b0;
        active  <= 1'b0;
        rdDir   <= 1'b0;
      end else begin
        if (busEv.startEv) begin
          active <= 1'b0;
          rdDir  <= 1'b0;
        end
        if (busEv.fall8 & busEv.firstByte) begin
          active <= busEv.hdrMatch;
          rdDir  <= ~tenBitMode & busEv.dirBit;
        end
        if (relWrEn)     relBit <= relWrVal;
        else if (clrRel) relBit <= 1'b0;
        if (addrWrStb)   updPend <= 1'b0;
        else if (setUpd) updPend <= 1'b1;
      end
    end
  end

  assign sclPullLow = pullQ;

endmodule

// File: rtl/i2c_stretch_top.sv
module i2c_stretch_top
  import i2c_stretch_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int BYTE_BITS  = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              tenBitMode,
  input  logic              stretchEn,
  input  logic              addrHoldEn,
  input  logic              dataHoldEn,
  input  logic              relWrEn,
  input  logic              relWrVal,
  input  logic              addrWrStb,
  output logic              sclPullLow,
  output logic              relBit,
  output logic              updPend
);

  busEvT busEv;
  logic  sclSync;
  logic  stopSeen;

  i2c_stretch_dp #(
    .ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS), .SYNC_DEPTH(SYNC_DEPTH)
  ) dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .tenBitMode(tenBitMode),
    .sclSync(sclSync), .busEv(busEv)
  );

  i2c_stretch_ctl ctl (
    .clk(clk), .rstN(rstN), .busEv(busEv), .sclSync(sclSync),
    .tenBitMode(tenBitMode), .stretchEn(stretchEn),
    .addrHoldEn(addrHoldEn), .dataHoldEn(dataHoldEn),
    .relWrEn(relWrEn), .relWrVal(relWrVal), .addrWrStb(addrWrStb),
    .sclPullLow(sclPullLow), .relBit(relBit), .updPend(updPend)
  );

  assign stopSeen = busEv.stopEv;

endmodule

// File: rtl/i2c_stretch_chk.sv
module i2c_stretch_chk (
  input logic clk,
  input logic rstN,
  input logic sclSync,
  input logic stopSeen,
  input logic relBit,
  input logic updPend,
  input logic addrWrStb,
  input logic sclPullLow
);

  // R1: a hold starts only after the synchronized clock was low
  a_r1_engage_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclPullLow) |-> !$past(sclSync));

  // R1: an engaged hold persists while it is still requested
  a_r1_hold_kept: assert property (@(posedge clk) disable iff (!rstN)
    (sclPullLow && (!relBit || updPend)) |=> sclPullLow);

  // R2: no request means the pad lets go on the next cycle
  a_r2_release: assert property (@(posedge clk) disable iff (!rstN)
    (relBit && !updPend) |=> !sclPullLow);

  // R7: address register write clears the pending update
  a_r7_addr_write: assert property (@(posedge clk) disable iff (!rstN)
    addrWrStb |=> !updPend);

  // R9: STOP leaves nothing stretched
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (relBit && !updPend));

endmodule

bind i2c_stretch_top i2c_stretch_chk chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .stopSeen(stopSeen),
  .relBit(relBit), .updPend(updPend), .addrWrStb(addrWrStb),
  .sclPullLow(sclPullLow)
);

// File: tb/i2c_stretch_top_test.sv
module i2c_stretch_top_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterScl = 1'b1, masterSda = 1'b1;
  logic [6:0] ownAddr = 7'h3A;
  logic tenBitMode = 1'b0, stretchEn = 1'b0, addrHoldEn = 1'b0, dataHoldEn = 1'b0;
  logic relWrEn = 1'b0, relWrVal = 1'b0, addrWrStb = 1'b0;
  logic sclPullLow, relBit, updPend;
  wire  busScl = masterScl & ~sclPullLow;
  wire  busSda = masterSda;

  always #10 clk = ~clk;  // 50 MHz

  i2c_stretch_top uut (
    .clk(clk), .rstN(rstN), .sclIn(busScl), .sdaIn(busSda),
    .ownAddr(ownAddr), .tenBitMode(tenBitMode), .stretchEn(stretchEn),
    .addrHoldEn(addrHoldEn), .dataHoldEn(dataHoldEn),
    .relWrEn(relWrEn), .relWrVal(relWrVal), .addrWrStb(addrWrStb),
    .sclPullLow(sclPullLow), .relBit(relBit), .updPend(updPend)
  );

  int vecs = 0, errs = 0;
  bit done = 0;

  // ---------------- behavioural reference, advanced at each falling clock edge
  bit [1:0] mSclP = 2'b11, mSdaP = 2'b11;
  bit mSclPr = 1, mSdaPr = 1, mArm = 0, mAct = 0, mRd = 0, mRel = 1, mUpd = 0, mPull = 0;
  int mCnt = 0, mIdx = 0, nc = 0;
  bit [7:0] mSh = 0;
  bit sRst = 0, sScl = 1, sSda = 1, sTen = 0, sStr = 0, sAh = 0, sDh = 0, sRw = 0, sRv = 0, sAw = 0;
  bit [6:0] sOwn = 0;
  bit cS, cD, fl, rs, st, sp, f8, f9, mt, clr, setU;

  always @(negedge clk) begin
    if (!sRst) begin
      mSclP = 2'b11; mSdaP = 2'b11; mSclPr = 1; mSdaPr = 1; mCnt = 0; mIdx = 0;
      mArm = 0; mSh = 0; mAct = 0; mRd = 0; mRel = 1; mUpd = 0; mPull = 0;
    end else begin
      cS = mSclP[1]; cD = mSdaP[1];
      fl = mSclPr & ~cS;  rs = ~mSclPr & cS;
      st = cS & mSclPr & mSdaPr & ~cD;  sp = cS & mSclPr & ~mSdaPr & cD;
      nc = (mCnt == 9) ? 1 : mCnt + 1;
      f8 = fl && mArm && nc == 8;
      f9 = fl && mArm && nc == 9;
      mt = sTen ? (mSh[7:3] == 5'b11110) : (mSh[7:1] == sOwn);
      clr = (f8 && mIdx == 0 && mt && sAh)
         || (f8 && mIdx != 0 && !(sTen && mIdx == 1) && mAct && !mRd && sDh)
         || (f9 && mAct && (mRd || sStr));
      setU = f9 && sTen && mAct && mIdx < 2;
      mPull = (!mRel || mUpd) && (mPull || !cS);
      if (sp) begin
        mRel = 1; mUpd = 0; mAct = 0; mRd = 0;
      end else begin
        if (st) begin mAct = 0; mRd = 0; end
        if (f8 && mIdx == 0) begin mAct = mt; mRd = !sTen && mSh[0]; end
        if (sRw) mRel = sRv; else if (clr) mRel = 0;
        if (sAw) mUpd = 0; else if (setU) mUpd = 1;
      end
      if (st) begin mCnt = 0; mArm = 0; mIdx = 0; end
      else if (rs) begin mSh = {mSh[6:0], cD}; mArm = 1; end
      else if (fl && mArm) begin mCnt = nc; if (nc == 9 && mIdx < 2) mIdx++; end
      mSclPr = cS; mSdaPr = cD;
      mSclP = {mSclP[0], sScl}; mSdaP = {mSdaP[0], sSda};
    end
    if (!done) begin
      vecs++;
      if (sclPullLow !== mPull || relBit !== mRel || updPend !== mUpd) begin
        errs++;
        if (sclPullLow !== mPull) $display("FAIL R1 sclPullLow actual %b expected %b at %0t", sclPullLow, mPull, $time);
        if (relBit !== mRel)      $display("FAIL R3 relBit actual %b expected %b at %0t", relBit, mRel, $time);
        if (updPend !== mUpd)     $display("FAIL R7 updPend actual %b expected %b at %0t", updPend, mUpd, $time);
      end
    end
    sRst = rstN; sScl = busScl; sSda = busSda; sTen = tenBitMode; sStr = stretchEn;
    sAh = addrHoldEn; sDh = dataHoldEn; sRw = relWrEn; sRv = relWrVal; sAw = addrWrStb;
    sOwn = ownAddr;
  end

  // ---------------- stimulus helpers
  int curByte = 0, curBit = 0;
  int posQ[$];
  bit updSeen[$];
  bit relSeen[$];

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input string tag, input int act, input int expv);
    vecs++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic checkPos(input string tag, input int n, input int e0, input int e1);
    int a0, a1;
    a0 = posQ.size() > 0 ? posQ[0] : -1;
    a1 = posQ.size() > 1 ? posQ[1] : -1;
    vecs++;
    if (posQ.size() != n || (n > 0 && a0 != e0) || (n > 1 && a1 != e1)) begin
      errs++;
      $display("FAIL %s stretch points actual n=%0d %0d %0d expected n=%0d %0d %0d",
               tag, posQ.size(), a0, a1, n, e0, e1);
    end
  endtask

  task automatic sclHigh();
    masterScl = 1'b1;
    cyc(6);
    if (busScl == 1'b0) begin
      posQ.push_back(curByte * 10 + curBit);
      updSeen.push_back(updPend);
      relSeen.push_back(relBit);
      cyc(4);
      if (updPend) begin addrWrStb = 1'b1; cyc(1); addrWrStb = 1'b0; end
      else begin relWrEn = 1'b1; relWrVal = 1'b1; cyc(1); relWrEn = 1'b0; end
      while (busScl == 1'b0) cyc(1);
    end
    cyc(12);
  endtask

  task automatic sendBit(input bit b, input int idx);
    curBit = idx;
    cyc(4); masterSda = b; cyc(12);
    sclHigh();
    masterScl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, input bit ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i], 8 - i);
    sendBit(ack, 9);
    curByte++;
  endtask

  task automatic startCond();
    posQ.delete(); updSeen.delete(); relSeen.delete();
    curByte = 0;
    masterSda = 1'b0; cyc(12); masterScl = 1'b0;
  endtask

  task automatic repStart();
    curBit = 0;
    cyc(4); masterSda = 1'b1; cyc(12);
    sclHigh();
    masterSda = 1'b0; cyc(12); masterScl = 1'b0;
    curByte = 0;
  endtask

  task automatic stopCond();
    curBit = 1;
    cyc(4); masterSda = 1'b0; cyc(12);
    sclHigh();
    masterSda = 1'b1; cyc(20);
  endtask

  task automatic setModes(input bit ten, input bit str, input bit ah, input bit dh);
    tenBitMode = ten; stretchEn = str; addrHoldEn = ah; dataHoldEn = dh;
    cyc(4);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R2 watchdog: bus hung, actual running expected finished");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  // ---------------- scenarios
  initial begin
    cyc(5);
    rstN = 1'b1;
    cyc(3);
    // R11 reset state
    check("R11 relBit after reset", relBit, 1);
    check("R11 updPend after reset", updPend, 0);
    check("R11 sclPullLow after reset", sclPullLow, 0);

    // R1 / R2: hold request on a high clock waits for the master to pull low
    relWrEn = 1'b1; relWrVal = 1'b0; cyc(1); relWrEn = 1'b0;
    cyc(8);
    check("R1 no pull while SCL high", sclPullLow, 0);
    masterSda = 1'b0; cyc(12); masterScl = 1'b0;
    cyc(1);
    check("R1 pull waits for synchronizer", sclPullLow, 0);
    cyc(6);
    check("R1 pull engaged on low clock", sclPullLow, 1);
    masterScl = 1'b1; cyc(8);
    check("R1 bus held after master release", busScl, 0);
    relWrEn = 1'b1; relWrVal = 1'b1; cyc(1); relWrEn = 1'b0;
    cyc(2);
    check("R2 bus rises after release bit set", busScl, 1);
    cyc(12); masterSda = 1'b1; cyc(20);

    // R3: read request stretches after each ACK slot
    setModes(0, 0, 0, 0);
    startCond(); sendByte(8'h75, 0); sendByte(8'hFF, 1); stopCond();
    checkPos("R3 read stretches", 2, 11, 21);

    // R4: general stretch on a write
    setModes(0, 1, 0, 0);
    startCond(); sendByte(8'h74, 0); sendByte(8'h5C, 0); stopCond();
    checkPos("R4 stretch after each ACK", 2, 11, 21);

    // R5: address hold, matched then unmatched
    setModes(0, 0, 1, 0);
    startCond(); sendByte(8'h74, 0); sendByte(8'h33, 0); stopCond();
    checkPos("R5 hold at 8th fall of matched address", 1, 9, 0);
    startCond(); sendByte(8'h20, 1); sendByte(8'h33, 1); stopCond();
    checkPos("R5 no hold for unmatched address", 0, 0, 0);

    // R6: data hold on received bytes
    setModes(0, 0, 0, 1);
    startCond(); sendByte(8'h74, 0); sendByte(8'h11, 0); sendByte(8'h22, 0); stopCond();
    checkPos("R6 hold at 8th fall of each data byte", 2, 19, 29);

    // R12: unmatched address with general stretch
    setModes(0, 1, 0, 0);
    startCond(); sendByte(8'h40, 1); sendByte(8'h55, 1); stopCond();
    checkPos("R12 unmatched transfer never stretches", 0, 0, 0);

    // R7 / R8: 10-bit mode address holds via update flag
    setModes(1, 0, 0, 0);
    startCond(); sendByte(8'hF0, 0); sendByte(8'h99, 0); sendByte(8'h12, 0); stopCond();
    checkPos("R8 holds after both address bytes", 2, 11, 21);
    for (int k = 0; k < updSeen.size(); k++) begin
      check("R7 update flag set during hold", updSeen[k], 1);
      check("R7 release bit untouched during hold", relSeen[k], 1);
    end

    // R10: repeated START in the middle of a byte restarts counting
    setModes(0, 0, 0, 0);
    startCond();
    for (int i = 7; i >= 4; i--) sendBit(1'(8'h74 >> i), 8 - i);
    repStart();
    sendByte(8'h75, 0); sendByte(8'hFF, 1); stopCond();
    checkPos("R10 fresh address after repeated START", 2, 11, 21);

    // R9: STOP forces the release bit set
    relWrEn = 1'b1; relWrVal = 1'b0; cyc(1); relWrEn = 1'b0;
    cyc(4);
    check("R9 release bit cleared by software", relBit, 0);
    masterSda = 1'b0; cyc(12); masterSda = 1'b1; cyc(8);
    check("R9 release bit set by STOP", relBit, 1);
    check("R9 no pull after STOP", sclPullLow, 0);

    cyc(10);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule